// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, called A and B, and moves a data word between them in either direction. Each direction has its own storage register, loaded by its own capture strobe, and its own driver enable. A per-direction source select decides whether the word sent across is the live value on the opposite bus or the word held in that direction's register. The block therefore covers four uses: live transfer A to B, live transfer B to A, storing a word from either bus, and replaying a stored word onto either bus.

The pads are split into an input, an output and a drive-enable per port, so the block can be synthesized and the three-state buffers are placed at the chip edge. Everything runs on one system clock. A capture strobe takes effect on the clock edge where it is first seen high. The source selects are registered before they reach a single-level multiplexer, so a select change moves the output from one whole source to the other on a clock edge, with no mixed value between them. A flag output reports when both ports are being driven at the same time.

Top module: `bus_xcvr_reg`

## Requirements
- R1: `b_drv` equals `b_drive_en` (active-high) and `a_drv` equals the inverse of `a_drive_en_n` (active-low). Both respond in the same cycle while `rst` is low.
- R2: When a capture strobe is high at a clock edge and was low at the edge before, that direction's register loads its source bus: the A-to-B register loads `a_in` on `a2b_strobe`, and the B-to-A register loads `b_in` on `b2a_strobe`. This happens whether or not either driver is enabled.
- R3: A register keeps its value at every other edge, including edges where its strobe stays high.
- R4: Each output takes its source from the select value seen at the previous clock edge. A select of 1 picks the stored word, and a select of 0 picks the live opposite bus. `b_out` follows `a2b_use_store`, and `a_out` follows `b2a_use_store`.
- R5: With live data selected, an output follows the opposite bus input in the same cycle, with no register in between.
- R6: `both_drive` is 1 exactly when `a_drv` and `b_drv` are both 1.
- R7: While synchronous active-high `rst` is high, both drivers are off, whatever the enables say. A reset edge clears both registers to zero and sets both selects to live.
- R8: In the cycle a select change takes effect, and in the cycle before it, each output equals the whole old source or the whole new source, never a mix of bits from both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Value seen on the A bus pads |
| a_out | output | 8 | Value to drive onto the A bus |
| a_drv | output | 1 | Drive enable for the A bus pads |
| b_in | input | 8 | Value seen on the B bus pads |
| b_out | output | 8 | Value to drive onto the B bus |
| b_drv | output | 1 | Drive enable for the B bus pads |
| a2b_strobe | input | 1 | Capture strobe for the A-to-B register |
| b2a_strobe | input | 1 | Capture strobe for the B-to-A register |
| a2b_use_store | input | 1 | B output source: 0 live A, 1 stored word |
| b2a_use_store | input | 1 | A output source: 0 live B, 1 stored word |
| b_drive_en | input | 1 | Enables B bus drivers, active high |
| a_drive_en_n | input | 1 | Enables A bus drivers, active low |
| both_drive | output | 1 | Both ports driven at once |

## Verification
The bench sweeps every 8-bit value through the live and stored paths in both directions. A datapath bit that is swapped or stuck therefore shows up as a wrong word. It holds a strobe high across a second edge while the bus changes. A design that captures on level instead of on the rising edge would then load the wrong word. It switches the selects while the live and stored words differ in every bit, and checks the output on both sides of the switch edge. An unregistered select, or a mixing multiplexer, would change the output a cycle early or produce a blend of the two words. It also drives both enable polarities and holds reset with the enables on, to catch an inverted enable or drivers that stay on during reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_NDIR = 2;
  localparam int unsigned DIR_A2B   = 0;
  localparam int unsigned DIR_B2A   = 1;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_t;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic rise;

  assign rise = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (rise) q <= din;
    end
  end

  AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && strobe && !$past(strobe)) |=> (q == $past(din))); // R2
  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !(strobe && !$past(strobe))) |=> $stable(q)); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (q == '0)); // R7
endmodule

// File: rtl/xcvr_src_sel.sv
module xcvr_src_sel
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         use_store,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         drive_en,
  output logic [W-1:0] dout,
  output logic         drv
);
  src_t sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SRC_LIVE;
    else     sel_q <= use_store ? SRC_STORED : SRC_LIVE;
  end

  always_comb begin
    unique case (sel_q)
      SRC_STORED: dout = stored;
      default:    dout = live;
    endcase
  end

  assign drv = drive_en & ~rst;

  AST_SEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (dout == ($past(use_store) ? stored : live))); // R4
  AST_OFF_IN_RESET: assert property (@(posedge clk)
    rst |-> !drv); // R7
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         a2b_strobe,
  input  logic         b2a_strobe,
  input  logic         a2b_use_store,
  input  logic         b2a_use_store,
  input  logic         b_drive_en,
  input  logic         a_drive_en_n,
  output logic         both_drive
);
  logic [W-1:0] src_bus [XCVR_NDIR];
  logic [W-1:0] held    [XCVR_NDIR];
  logic [W-1:0] dst_out [XCVR_NDIR];
  logic         strobe  [XCVR_NDIR];
  logic         usel    [XCVR_NDIR];
  logic         den     [XCVR_NDIR];
  logic         ddrv    [XCVR_NDIR];

  assign src_bus[DIR_A2B] = a_in;
  assign src_bus[DIR_B2A] = b_in;
  assign strobe[DIR_A2B]  = a2b_strobe;
  assign strobe[DIR_B2A]  = b2a_strobe;
  assign usel[DIR_A2B]    = a2b_use_store;
  assign usel[DIR_B2A]    = b2a_use_store;
  assign den[DIR_A2B]     = b_drive_en;
  assign den[DIR_B2A]     = ~a_drive_en_n;

  for (genvar d = 0; d < XCVR_NDIR; d++) begin : g_dir
    xcvr_capture_reg #(.W(W)) cap_i (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe[d]),
      .din    (src_bus[d]),
      .q      (held[d])
    );
    xcvr_src_sel #(.W(W)) sel_i (
      .clk       (clk),
      .rst       (rst),
      .use_store (usel[d]),
      .live      (src_bus[d]),
      .stored    (held[d]),
      .drive_en  (den[d]),
      .dout      (dst_out[d]),
      .drv       (ddrv[d])
    );
  end

  assign b_out      = dst_out[DIR_A2B];
  assign b_drv      = ddrv[DIR_A2B];
  assign a_out      = dst_out[DIR_B2A];
  assign a_drv      = ddrv[DIR_B2A];
  assign both_drive = a_drv & b_drv;

  AST_CONTENTION_FLAG: assert property (@(posedge clk) disable iff (rst)
    (a_drv && b_drv) |-> both_drive); // R6
  AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    both_drive |-> (b_drive_en && !a_drive_en_n)); // R6
  AST_ENABLE_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (b_drv == b_drive_en) && (a_drv == !a_drive_en_n)); // R1
endmodule

// File: tb/bus_xcvr_reg_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_drv, b_drv, both_drive;
  logic a2b_strobe, b2a_strobe, a2b_use_store, b2a_use_store;
  logic b_drive_en, a_drive_en_n;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_xcvr_reg #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .a2b_strobe(a2b_strobe), .b2a_strobe(b2a_strobe),
    .a2b_use_store(a2b_use_store), .b2a_use_store(b2a_use_store),
    .b_drive_en(b_drive_en), .a_drive_en_n(a_drive_en_n),
    .both_drive(both_drive)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; a_in = 8'h5A; b_in = 8'hC3;
    a2b_strobe = 0; b2a_strobe = 0; a2b_use_store = 0; b2a_use_store = 0;
    b_drive_en = 1; a_drive_en_n = 0;
    repeat (3) tick();
    // R7: drivers off during reset even with enables on
    chk("R7 b_drv in reset", {7'b0, b_drv}, 8'h0);
    chk("R7 a_drv in reset", {7'b0, a_drv}, 8'h0);
    b_drive_en = 0; a_drive_en_n = 1;
    a2b_use_store = 1; b2a_use_store = 1;
    rst = 0;
    #1;
    // R7: stores cleared, select reset to live (select input ignored until next edge)
    chk("R7 b_out live after reset", b_out, 8'h5A);
    tick();
    chk("R7 a2b store cleared", b_out, 8'h00);
    chk("R7 b2a store cleared", a_out, 8'h00);

    // R1 / R6: enable polarity and contention flag, all combinations
    for (int e = 0; e < 4; e++) begin
      b_drive_en = e[0]; a_drive_en_n = e[1];
      #1;
      chk("R1 b_drv", {7'b0, b_drv}, {7'b0, e[0]});
      chk("R1 a_drv", {7'b0, a_drv}, {7'b0, ~e[1]});
      chk("R6 both_drive", {7'b0, both_drive}, {7'b0, e[0] & ~e[1]});
    end
    b_drive_en = 0; a_drive_en_n = 1;

    // R5: live path, every value both directions
    a2b_use_store = 0; b2a_use_store = 0;
    tick();
    for (int v = 0; v < 256; v++) begin
      a_in = v[7:0]; b_in = ~v[7:0];
      #1;
      chk("R5 live A to B", b_out, v[7:0]);
      chk("R5 live B to A", a_out, ~v[7:0]);
    end

    // R2 / R3: capture on rising strobe, hold on high strobe, drivers disabled
    a2b_use_store = 1; b2a_use_store = 1;
    tick();
    for (int v = 0; v < 256; v++) begin
      a_in = v[7:0]; b_in = v[7:0] ^ 8'hA5;
      a2b_strobe = 1; b2a_strobe = 1;
      tick();
      chk("R2 capture A", b_out, v[7:0]);
      chk("R2 capture B", a_out, v[7:0] ^ 8'hA5);
      a_in = ~v[7:0]; b_in = v[7:0] ^ 8'h5A;
      tick();
      chk("R3 hold A strobe high", b_out, v[7:0]);
      chk("R3 hold B strobe high", a_out, v[7:0] ^ 8'hA5);
      a2b_strobe = 0; b2a_strobe = 0;
      tick();
      chk("R3 hold A strobe low", b_out, v[7:0]);
    end

    // R8 / R4: select switch, stored=00 live=FF on A->B
    a_in = 8'h00; a2b_strobe = 1; tick(); a2b_strobe = 0; tick();
    a_in = 8'hFF;
    for (int k = 0; k < 4; k++) begin
      a2b_use_store = k[0];
      #1;
      chk("R8 before switch edge", b_out, k[0] ? 8'hFF : 8'h00);
      tick();
      chk("R4 after switch edge", b_out, k[0] ? 8'h00 : 8'hFF);
    end

    // R7: reset clears stores mid-run
    b2a_strobe = 1; b_in = 8'h3C; tick(); b2a_strobe = 0;
    rst = 1; tick(); rst = 0;
    a2b_use_store = 1; b2a_use_store = 1; tick();
    chk("R7 reset clears A2B", b_out, 8'h00);
    chk("R7 reset clears B2A", a_out, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule